// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This engine runs the SHA-256 compression function over 512-bit message blocks. Each block arrives as sixteen 32-bit words. The result is the 256-bit digest, presented as eight 32-bit chaining words. A message begins with a start pulse, which loads the standard initial hash values. The engine then raises its word request. An upstream source answers each request with an acknowledge and a data word.

Rounds 0 to 15 run in the same cycles as word arrival, one round per accepted word. Rounds 16 to 63 take their schedule words from a 16-word sliding window. After round 63 there is one further cycle, in which the working variables are added back into the chaining state. So only 49 cycles separate the sixteenth accepted word from the point where the block is complete.

The source marks the final block of a message by driving the last-block flag together with that block's sixteenth word. Padding and length words are the source's job: every block it delivers is already padded. A clock enable freezes the whole engine. A synchronous active-high reset clears it.

Top module: `sha256_core`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `req` and `ready` are both 0.
- R2: A `start` pulse sampled with `en` high loads the initial hash values and abandons any block in progress. The next cycle has `req` = 1 and `ready` = 0.
- R3: `req` stays high until sixteen words of the current block have been accepted. It is low in the cycle after the sixteenth acceptance. A word is accepted on a clock edge where `en`, `req` and `ack` are all 1, and word 0 of the block (bits 511:480) comes first.
- R4: While `req` is high, an edge with `ack` low accepts no word and leaves `req` high. The stall moves no round forward.
- R5: For a block that is not the last one, `req` rises again after exactly 49 enabled clock edges following the edge that accepted the sixteenth word.
- R6: The `last` input is sampled only with the sixteenth word of a block. When it was 1, `ready` rises after exactly 49 enabled edges following that acceptance, `req` stays low, and `digest` holds the SHA-256 result.
- R7: Blocks of one message chain: each block's compression starts from the chaining state left by the previous block.
- R8: `ready` and `digest` stay constant until the next `start` sampled with `en` high. `ack`, `din` and `last` have no effect in that time.
- R9: With `en` low, no state changes. Words are not accepted and rounds do not advance, so the 49-cycle interval counts only enabled edges.
- R10: `digest` bits 255:224 carry chaining word H0, and H7 sits in bits 31:0.
- R11: A `last` value driven with any word other than the sixteenth has no effect on whether the block ends the message.
- R12: While `req` is low, `ack` and `din` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; low freezes every register |
| start | input | 1 | Begin a new message |
| ack | input | 1 | Source presents a word on `din` this cycle |
| din | input | 32 | Message word |
| last | input | 1 | With the sixteenth word: this block ends the message |
| req | output | 1 | Engine can accept a word of the current block |
| ready | output | 1 | `digest` holds the final result |
| digest | output | 256 | Chaining words H0 (MSB) to H7 (LSB) |

## Verification
Known single-block vectors pin the round constants, the sigma rotations and the word order of the digest. A wrong constant or a swapped rotation corrupts every digest. Random multi-block messages with random acknowledge gaps and clock-enable gaps expose three kinds of fault: a schedule window that shifts on stalls, dropped chaining between blocks, and a counter that counts disabled edges. Each of these shows up as a wrong digest or an interval other than 49.

Three further cases close the gaps:
- A `start` in the middle of a block catches leftover state from the abandoned block.
- Junk on `ack` and `din` during rounds 16 to 63 catches a design that takes words while `req` is low.
- A random `last` on early words catches a design that ends the message early.

// File: rtl/sha_pkg.sv
package sha_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 8;
  localparam int BLK_WORDS   = 16;
  localparam int ROUNDS      = 64;
  localparam int RND_W       = $clog2(ROUNDS);
  localparam int DIG_W       = WORD_W * STATE_WORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_ADD} phase_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t lit_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t lit_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t iv_word(input int i);
    case (i)
      0: return 32'h6a09e667;
      1: return 32'hbb67ae85;
      2: return 32'h3c6ef372;
      3: return 32'ha54ff53a;
      4: return 32'h510e527f;
      5: return 32'h9b05688c;
      6: return 32'h1f83d9ab;
      default: return 32'h5be0cd19;
    endcase
  endfunction
endpackage

// File: rtl/sha_kconst.sv
module sha_kconst
  import sha_pkg::*;
(
  input  logic [RND_W-1:0] idx,
  output word_t            k
);
  always_comb begin
    case (int'(idx))
      0:  k = 32'h428a2f98;  1:  k = 32'h71374491;
      2:  k = 32'hb5c0fbcf;  3:  k = 32'he9b5dba5;
      4:  k = 32'h3956c25b;  5:  k = 32'h59f111f1;
      6:  k = 32'h923f82a4;  7:  k = 32'hab1c5ed5;
      8:  k = 32'hd807aa98;  9:  k = 32'h12835b01;
      10: k = 32'h243185be;  11: k = 32'h550c7dc3;
      12: k = 32'h72be5d74;  13: k = 32'h80deb1fe;
      14: k = 32'h9bdc06a7;  15: k = 32'hc19bf174;
      16: k = 32'he49b69c1;  17: k = 32'hefbe4786;
      18: k = 32'h0fc19dc6;  19: k = 32'h240ca1cc;
      20: k = 32'h2de92c6f;  21: k = 32'h4a7484aa;
      22: k = 32'h5cb0a9dc;  23: k = 32'h76f988da;
      24: k = 32'h983e5152;  25: k = 32'ha831c66d;
      26: k = 32'hb00327c8;  27: k = 32'hbf597fc7;
      28: k = 32'hc6e00bf3;  29: k = 32'hd5a79147;
      30: k = 32'h06ca6351;  31: k = 32'h14292967;
      32: k = 32'h27b70a85;  33: k = 32'h2e1b2138;
      34: k = 32'h4d2c6dfc;  35: k = 32'h53380d13;
      36: k = 32'h650a7354;  37: k = 32'h766a0abb;
      38: k = 32'h81c2c92e;  39: k = 32'h92722c85;
      40: k = 32'ha2bfe8a1;  41: k = 32'ha81a664b;
      42: k = 32'hc24b8b70;  43: k = 32'hc76c51a3;
      44: k = 32'hd192e819;  45: k = 32'hd6990624;
      46: k = 32'hf40e3585;  47: k = 32'h106aa070;
      48: k = 32'h19a4c116;  49: k = 32'h1e376c08;
      50: k = 32'h2748774c;  51: k = 32'h34b0bcb5;
      52: k = 32'h391c0cb3;  53: k = 32'h4ed8aa4a;
      54: k = 32'h5b9cca4f;  55: k = 32'h682e6ff3;
      56: k = 32'h748f82ee;  57: k = 32'h78a5636f;
      58: k = 32'h84c87814;  59: k = 32'h8cc70208;
      60: k = 32'h90befffa;  61: k = 32'ha4506ceb;
      62: k = 32'hbef9a3f7;  63: k = 32'hc67178f2;
      default: k = '0;
    endcase
  end
endmodule

// File: rtl/sha_sched.sv
module sha_sched
  import sha_pkg::*;
(
  input  logic  clk,
  input  logic  step,
  input  logic  ext,
  input  word_t din,
  output word_t w_cur
);
  // Window slot BLK_WORDS-1 holds the newest word, W[t-1]; slot 0 holds W[t-16].
  word_t win [BLK_WORDS];

  assign w_cur = ext ? din
               : lit_s1(win[BLK_WORDS-2]) + win[BLK_WORDS-7]
                 + lit_s0(win[1]) + win[0];

  always_ff @(posedge clk) begin
    if (step) begin
      for (int i = 0; i < BLK_WORDS-1; i++) win[i] <= win[i+1];
      win[BLK_WORDS-1] <= w_cur;
    end
  end
endmodule

// File: rtl/sha_round.sv
module sha_round
  import sha_pkg::*;
(
  input  word_t v   [STATE_WORDS],
  input  word_t k,
  input  word_t w,
  output word_t nv  [STATE_WORDS]
);
  word_t t1, t2;

  always_comb begin
    t1 = v[7] + big_s1(v[4]) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + k + w;
    t2 = big_s0(v[0]) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
    for (int i = 1; i < STATE_WORDS; i++) nv[i] = v[i-1];
    nv[0] = t1 + t2;
    nv[4] = v[3] + t1;
  end
endmodule

// File: rtl/sha256_core.sv
module sha256_core
  import sha_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              ack,
  input  logic [WORD_W-1:0] din,
  input  logic              last,
  output logic              req,
  output logic              ready,
  output logic [DIG_W-1:0]  digest
);
  localparam logic [RND_W-1:0] LAST_FEED = RND_W'(BLK_WORDS - 1);
  localparam logic [RND_W-1:0] LAST_RND  = RND_W'(ROUNDS - 1);

  phase_t           phase_q;
  logic [RND_W-1:0] cnt_q;
  logic             last_q, ready_q;
  word_t            h_q   [STATE_WORDS];
  word_t            v_q   [STATE_WORDS];
  word_t            v_nxt [STATE_WORDS];
  word_t            k_cur, w_cur;
  logic             feeding, step;

  assign feeding = (phase_q == PH_RUN) && (cnt_q <= LAST_FEED);
  assign step    = en && !start && (phase_q == PH_RUN) && (!feeding || ack);
  assign req     = feeding;
  assign ready   = ready_q;

  sha_kconst u_k (.idx(cnt_q), .k(k_cur));

  sha_sched u_sched (
    .clk  (clk),
    .step (step),
    .ext  (feeding),
    .din  (din),
    .w_cur(w_cur)
  );

  sha_round u_round (.v(v_q), .k(k_cur), .w(w_cur), .nv(v_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      ready_q <= 1'b0;
      for (int i = 0; i < STATE_WORDS; i++) begin
        h_q[i] <= '0;
        v_q[i] <= '0;
      end
    end else if (en) begin
      if (start) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
        last_q  <= 1'b0;
        ready_q <= 1'b0;
        for (int i = 0; i < STATE_WORDS; i++) begin
          h_q[i] <= iv_word(i);
          v_q[i] <= iv_word(i);
        end
      end else begin
        case (phase_q)
          PH_RUN: if (step) begin
            v_q   <= v_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_FEED) last_q <= last;
            if (cnt_q == LAST_RND) phase_q <= PH_ADD;
          end
          PH_ADD: begin
            for (int i = 0; i < STATE_WORDS; i++) begin
              h_q[i] <= h_q[i] + v_q[i];
              v_q[i] <= h_q[i] + v_q[i];
            end
            cnt_q <= '0;
            if (last_q) begin
              ready_q <= 1'b1;
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_RUN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < STATE_WORDS; g++) begin : g_dig
    assign digest[DIG_W-1-g*WORD_W -: WORD_W] = h_q[g];
  end

  // Assertions
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !req && !ready);

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (en && start) |=> req && !ready);

  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !start && req && ack && cnt_q == LAST_FEED) |=> !req);

  p_ack_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !(en && start)) |=> req && $stable(cnt_q));

  p_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
    ready |-> !req);

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ready && !(en && start)) |=> ready && $stable(digest));

  p_en_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q) && $stable(phase_q) && $stable(ready_q) && $stable(digest));
endmodule

// File: tb/sha256_core_tb.sv
`timescale 1ns/1ps
module sha256_core_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b1, start = 1'b0, ack = 1'b0, last = 1'b0;
  logic [31:0]  din = '0;
  logic         req, ready;
  logic [255:0] digest;

  int tests = 0;
  int fails = 0;
  logic [511:0] blocks [4];

  localparam logic [255:0] ABC_DIG =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] EMPTY_DIG =
    256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;

  always #2 clk = ~clk;

  sha256_core u_dut (
    .clk(clk), .rst(rst), .en(en), .start(start), .ack(ack),
    .din(din), .last(last), .req(req), .ready(ready), .digest(digest)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] big0(input logic [31:0] x);
    return rr(x, 2) ^ rr(x, 13) ^ rr(x, 22);
  endfunction
  function automatic logic [31:0] big1(input logic [31:0] x);
    return rr(x, 6) ^ rr(x, 11) ^ rr(x, 25);
  endfunction
  function automatic logic [31:0] sm0(input logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] sm1(input logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [31:0] kref(input int t);
    logic [31:0] tbl [64] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};
    return tbl[t];
  endfunction

  localparam logic [255:0] IV_REF =
    256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

  function automatic logic [255:0] ref_compress(input logic [255:0] hin, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] s [8];
    logic [31:0] t1, t2;
    logic [255:0] hout;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++) w[t] = sm1(w[t-2]) + w[t-7] + sm0(w[t-15]) + w[t-16];
    for (int i = 0; i < 8; i++) s[i] = hin[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = s[7] + big1(s[4]) + ((s[4] & s[5]) ^ (~s[4] & s[6])) + kref(t) + w[t];
      t2 = big0(s[0]) + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
      for (int i = 7; i > 0; i--) s[i] = s[i-1];
      s[4] = s[4] + t1;
      s[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) hout[255-32*i -: 32] = hin[255-32*i -: 32] + s[i];
    return hout;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_msg();
    @(negedge clk); start = 1'b1; en = 1'b1; ack = 1'b0; last = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(req === 1'b1 && ready === 1'b0, "R2 start gives req=1 ready=0",
        {254'd0, req, ready}, 256'd2);
  endtask

  task automatic feed_block(input logic [511:0] blk, input bit is_last, input int nw,
                            input bit ra, input bit re);
    int k = 0;
    while (k < nw) begin
      logic a_v, e_v;
      @(negedge clk);
      chk(req === 1'b1, "R3 req high while words pending", {255'd0, req}, 256'd1);
      a_v = ra ? ($urandom % 4 != 0) : 1'b1;
      e_v = re ? ($urandom % 5 != 0) : 1'b1;
      ack = a_v; en = e_v;
      din = blk[511-32*k -: 32];
      // R11: last on words other than the sixteenth is random junk
      last = (k == 15) ? is_last : 1'($urandom % 2);
      if (req && a_v && e_v) k++;
    end
  endtask

  task automatic wait_done(input bit re, output int n);
    n = 0;
    forever begin
      logic e_v;
      @(negedge clk);
      if (req || ready || n > 300) begin
        ack = 1'b0; last = 1'b0; en = 1'b1;
        break;
      end
      e_v = re ? ($urandom % 3 != 0) : 1'b1;
      en = e_v;
      ack = 1'($urandom % 2);   // R12: junk while req is low
      din = $urandom;
      last = 1'($urandom % 2);
      if (e_v) n++;
    end
  endtask

  task automatic run_msg(input int nb, input bit ra, input bit re,
                         input logic [255:0] known, input bit use_known,
                         output logic [255:0] exp);
    int n;
    exp = IV_REF;
    for (int b = 0; b < nb; b++) exp = ref_compress(exp, blocks[b]);
    if (use_known)
      chk(exp == known, "R6 bench model vs known vector", exp, known);
    start_msg();
    for (int b = 0; b < nb; b++) begin
      feed_block(blocks[b], b == nb - 1, 16, ra, re);
      wait_done(re, n);
      chk(n == 49, (b == nb - 1) ? "R6 ready after 49 enabled edges" :
                                   "R5 req back after 49 enabled edges (R9 en gaps)",
          256'(n), 256'd49);
      if (b < nb - 1)
        chk(req === 1'b1 && ready === 1'b0, "R5 next block requested, R11 not ended",
            {254'd0, req, ready}, 256'd2);
    end
    chk(ready === 1'b1 && req === 1'b0, "R6 ready set, req low",
        {254'd0, req, ready}, 256'd1);
    chk(digest == exp, (nb > 1) ? "R7 chained digest" : "R6 digest", digest, exp);
  endtask

  task automatic hold_check(input logic [255:0] exp);
    repeat (20) begin
      @(negedge clk);
      en = 1'($urandom % 2); ack = 1'($urandom % 2);
      din = $urandom; last = 1'($urandom % 2);
      chk(ready === 1'b1 && digest == exp, "R8 ready and digest hold", digest, exp);
    end
    en = 1'b1; ack = 1'b0; last = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [255:0] exp;
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req === 1'b0 && ready === 1'b0, "R1 quiet in reset", {254'd0, req, ready}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req === 1'b0 && ready === 1'b0, "R1 quiet after reset", {254'd0, req, ready}, 256'd0);

    // Known vector: "abc"
    blocks[0] = {32'h61626380, 448'd0, 32'h00000018};
    run_msg(1, 1'b0, 1'b0, ABC_DIG, 1'b1, exp);
    chk(digest[255:224] == 32'hba7816bf, "R10 H0 in top word",
        {224'd0, digest[255:224]}, {224'd0, 32'hba7816bf});
    chk(digest[31:0] == 32'hf20015ad, "R10 H7 in bottom word",
        {224'd0, digest[31:0]}, {224'd0, 32'hf20015ad});
    hold_check(exp);

    // Known vector: empty message
    blocks[0] = {32'h80000000, 480'd0};
    run_msg(1, 1'b1, 1'b0, EMPTY_DIG, 1'b1, exp);

    // Restart in the middle of a block, then a known message
    start_msg();
    feed_block({16{$urandom}}, 1'b0, 7, 1'b1, 1'b0);
    blocks[0] = {32'h61626380, 448'd0, 32'h00000018};
    run_msg(1, 1'b1, 1'b1, ABC_DIG, 1'b1, exp);
    chk(digest == ABC_DIG, "R2 restart discards partial block", digest, ABC_DIG);

    // Random multi-block messages, stalls and enable gaps
    for (int it = 0; it < 8; it++) begin
      int nb;
      nb = 1 + ($urandom % 3);
      for (int b = 0; b < nb; b++)
        for (int w = 0; w < 16; w++) blocks[b][511-32*w -: 32] = $urandom;
      run_msg(nb, (it % 2) == 1, it >= 4, '0, 1'b0, exp);
      if (it == 5) hold_check(exp);
    end

    // Reset in the middle of the rounds
    for (int w = 0; w < 16; w++) blocks[0][511-32*w -: 32] = $urandom;
    start_msg();
    feed_block(blocks[0], 1'b0, 16, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(req === 1'b0 && ready === 1'b0, "R1 reset mid-run clears", {254'd0, req, ready}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req === 1'b0 && ready === 1'b0, "R1 idle after mid-run reset", {254'd0, req, ready}, 256'd0);
    blocks[0] = {32'h80000000, 480'd0};
    run_msg(1, 1'b0, 1'b0, EMPTY_DIG, 1'b1, exp);
    n = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule